// File: doc/BRIEF.md
# Segment Access Protection Checker

This block screens one memory access against a cached segment descriptor before the access is allowed to reach memory. A request supplies an offset, a size in bytes and an access kind (data read, data write or instruction fetch). The descriptor supplies a base, a limit, a present flag, a privilege level, an executable flag and a read/write permission flag. The requester supplies its selector's requested privilege level, its current privilege level and a protection-enable bit.

The checks run in a fixed order: limit, then presence, then privilege, then type. Only the first failing check is reported. In unprotected (real) mode only the limit check applies. One clock edge after a request strobe, the block pulses either a grant, which comes with the linear address (base plus offset), or a fault, which comes with a fault vector. A fault vector distinguishes a general-protection fault from a segment-not-present fault.

Top module: `seg_guard`

## Requirements
- R1: While reset is held, and directly after it, `grant` and `fault` are 0 and `faultVec` and `linAddr` are 0.
- R2: A request with `reqValid` high at a rising edge yields exactly one of `grant` or `fault`, high from that edge for one cycle. With no request, both stay low and `faultVec` reads 0.
- R3: The last byte is computed as `reqOffset + reqSize - 1` with one extra carry bit. If it exceeds `descLimit`, the result is a fault with vector 13, in both modes. An offset that wraps past 2^32 therefore exceeds the limit.
- R4: When `protEn` is 0, only the limit check applies. Present, privilege and type mismatches have no effect, and the request is granted.
- R5: With `protEn` 1 and `descPresent` 0, the result is a fault with vector 11, not 13.
- R6: For data reads (`reqKind` 2'b00) and data writes (2'b01), a fault with vector 13 is raised when `selRpl > descDpl` or `curPl > descDpl`.
- R7: For instruction fetches (`reqKind` 2'b10), `selRpl` is ignored. Only `curPl > descDpl` causes a fault with vector 13.
- R8: A fetch from a segment with `descExec` 0 is a fault with vector 13.
- R9: A read of an executable segment with `descRw` 0 is a fault with vector 13. A read of a data segment is allowed whatever `descRw` is. Code 2'b11 is handled as a read.
- R10: Any write to an executable segment is a fault with vector 13, and so is a write to a data segment with `descRw` 0.
- R11: The check order is limit, then present, then privilege, then type. The vector reported is that of the first check that fails.
- R12: On a grant, `linAddr` becomes `descBase + reqOffset` modulo 2^32. It keeps its value through faults and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| reqOffset | input | 32 | Offset within the segment |
| reqSize | input | 3 | Access size in bytes (1 or more) |
| descBase | input | 32 | Segment base |
| descLimit | input | 32 | Highest valid offset |
| descPresent | input | 1 | Segment present |
| descDpl | input | 2 | Descriptor privilege level |
| descExec | input | 1 | Segment is executable |
| descRw | input | 1 | Readable (code) / writable (data) |
| selRpl | input | 2 | Selector requested privilege level |
| curPl | input | 2 | Current privilege level |
| protEn | input | 1 | Protection enabled |
| linAddr | output | 32 | Linear address of the last granted access |
| grant | output | 1 | Access allowed pulse |
| fault | output | 1 | Access refused pulse |
| faultVec | output | 8 | Fault vector (13 or 11) while `fault` is high |

## Verification
Every result is due exactly one rising edge after the request is presented. `grant`, `fault`, `faultVec` and `linAddr` all settle together at that edge. The driver tags each expected item with the cycle number of its capture edge. The monitor samples on the falling edge of that same cycle and compares only then. On every other falling edge it requires both strobes to be low, which also checks that each pulse lasts a single cycle.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_ALTRD = 2'b11
  } accKind_e;

  // results of the individual checks, before ordering
  typedef struct packed {
    logic limitBad;
    logic absent;
    logic privBad;
    logic typeBad;
  } chkFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
  } ctlStrobes_t;

endpackage

// File: rtl/seg_guard_dp.sv
module seg_guard_dp
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int PL_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [ADDR_W-1:0] descLimit,
  input  logic              descPresent,
  input  logic [PL_W-1:0]   descDpl,
  input  logic              descExec,
  input  logic              descRw,
  input  logic [PL_W-1:0]   selRpl,
  input  logic [PL_W-1:0]   curPl,
  input  logic              protEn,
  input  ctlStrobes_t       strobes,
  output chkFlags_t         flags,
  output logic [ADDR_W-1:0] linAddr
);

  localparam int WIDE_W = ADDR_W + 1;

  logic [WIDE_W-1:0] lastByte;
  logic [WIDE_W-1:0] sizeWide;
  logic [ADDR_W-1:0] sumAddr;
  logic              isFetch;
  logic              isWrite;
  logic              cplOver;
  logic              rplOver;
  logic              typeMiss;

  assign sizeWide = {{(WIDE_W-SIZE_W){1'b0}}, reqSize};
  assign lastByte = {1'b0, reqOffset} + sizeWide - WIDE_W'(1);
  assign isFetch  = (reqKind == KIND_FETCH);
  assign isWrite  = (reqKind == KIND_WRITE);
  assign cplOver  = (curPl > descDpl);
  assign rplOver  = (selRpl > descDpl);
  assign sumAddr  = descBase + reqOffset;

  always_comb begin
    if (isFetch)      typeMiss = ~descExec;
    else if (isWrite) typeMiss = descExec | ~descRw;
    else              typeMiss = descExec & ~descRw;
  end

  always_comb begin
    flags.limitBad = (lastByte > {1'b0, descLimit});
    flags.absent   = protEn & ~descPresent;
    flags.privBad  = protEn & (cplOver | (~isFetch & rplOver));
    flags.typeBad  = protEn & typeMiss;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 linAddr <= '0;
    else if (strobes.loadAddr) linAddr <= sumAddr;
  end

  assert_addr_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> linAddr == $past(descBase + reqOffset));

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAddr |=> $stable(linAddr));

  assert_real_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |-> !(flags.absent || flags.privBad || flags.typeBad));

endmodule

// File: rtl/seg_guard_ctl.sv
module seg_guard_ctl
  import seg_guard_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int VEC_GP = 13,
  parameter int VEC_NP = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  chkFlags_t        flags,
  output ctlStrobes_t      strobes,
  output logic             grant,
  output logic             fault,
  output logic [VEC_W-1:0] faultVec
);

  localparam logic [VEC_W-1:0] GP_CODE = VEC_W'(VEC_GP);
  localparam logic [VEC_W-1:0] NP_CODE = VEC_W'(VEC_NP);

  logic             anyBad;
  logic [VEC_W-1:0] firstVec;

  // ordered selection: limit, present, privilege, type
  always_comb begin
    anyBad   = 1'b1;
    firstVec = GP_CODE;
    if (flags.limitBad)     firstVec = GP_CODE;
    else if (flags.absent)  firstVec = NP_CODE;
    else if (flags.privBad) firstVec = GP_CODE;
    else if (flags.typeBad) firstVec = GP_CODE;
    else begin
      anyBad   = 1'b0;
      firstVec = '0;
    end
  end

  assign strobes.loadAddr = reqValid & ~anyBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant    <= 1'b0;
      fault    <= 1'b0;
      faultVec <= '0;
    end else begin
      grant    <= reqValid & ~anyBad;
      fault    <= reqValid & anyBad;
      faultVec <= (reqValid & anyBad) ? firstVec : '0;
    end
  end

  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && fault));

  assert_result_due_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (grant || fault));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(grant || fault));

  assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultVec == GP_CODE || faultVec == NP_CODE));

  assert_limit_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && flags.limitBad) |=> (fault && faultVec == GP_CODE));

endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int PL_W   = 2,
  parameter int VEC_W  = 8,
  parameter int VEC_GP = 13,
  parameter int VEC_NP = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [ADDR_W-1:0] descLimit,
  input  logic              descPresent,
  input  logic [PL_W-1:0]   descDpl,
  input  logic              descExec,
  input  logic              descRw,
  input  logic [PL_W-1:0]   selRpl,
  input  logic [PL_W-1:0]   curPl,
  input  logic              protEn,
  output logic [ADDR_W-1:0] linAddr,
  output logic              grant,
  output logic              fault,
  output logic [VEC_W-1:0]  faultVec
);

  chkFlags_t   flags;
  ctlStrobes_t strobes;

  seg_guard_dp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PL_W(PL_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqKind(reqKind), .reqOffset(reqOffset),
    .reqSize(reqSize), .descBase(descBase), .descLimit(descLimit),
    .descPresent(descPresent), .descDpl(descDpl), .descExec(descExec),
    .descRw(descRw), .selRpl(selRpl), .curPl(curPl), .protEn(protEn),
    .strobes(strobes), .flags(flags), .linAddr(linAddr)
  );

  seg_guard_ctl #(.VEC_W(VEC_W), .VEC_GP(VEC_GP), .VEC_NP(VEC_NP)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .flags(flags),
    .strobes(strobes), .grant(grant), .fault(fault), .faultVec(faultVec)
  );

  assert_np_only_prot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fault && faultVec == VEC_W'(VEC_NP)) |-> $past(protEn));

endmodule

// File: tb/sim_seg_guard.sv
`timescale 1ns/1ps
module sim_seg_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [31:0] reqOffset = '0;
  logic [2:0]  reqSize = 3'd1;
  logic [31:0] descBase = '0;
  logic [31:0] descLimit = '0;
  logic        descPresent = 1'b1;
  logic [1:0]  descDpl = '0;
  logic        descExec = 1'b0;
  logic        descRw = 1'b1;
  logic [1:0]  selRpl = '0;
  logic [1:0]  curPl = '0;
  logic        protEn = 1'b0;
  logic [31:0] linAddr;
  logic        grant;
  logic        fault;
  logic [7:0]  faultVec;

  always #2.5 clk = ~clk;

  seg_guard u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqOffset(reqOffset), .reqSize(reqSize), .descBase(descBase),
    .descLimit(descLimit), .descPresent(descPresent), .descDpl(descDpl),
    .descExec(descExec), .descRw(descRw), .selRpl(selRpl), .curPl(curPl),
    .protEn(protEn), .linAddr(linAddr), .grant(grant), .fault(fault),
    .faultVec(faultVec)
  );

  typedef struct {
    bit          g;
    bit [7:0]    vec;
    bit [31:0]   addr;
    int          due;
    string       tag;
  } item_t;

  item_t     sbq[$];
  int        nRun = 0;
  int        nFail = 0;
  int        cyc = 0;
  bit        live = 1'b0;
  bit        done = 1'b0;
  bit [31:0] expAddr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string got, input string want);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %s expected %s", tag, got, want);
    end
  endtask

  task automatic req(input string tag, input bit [1:0] k, input bit [31:0] off,
                     input bit [2:0] sz, input bit [31:0] base, input bit [31:0] lim,
                     input bit p, input bit [1:0] dpl, input bit ex, input bit rw,
                     input bit [1:0] rpl, input bit [1:0] cpl, input bit pe);
    item_t it;
    bit [32:0] last;
    bit isF, isW, tBad;
    @(posedge clk); #2;
    reqValid = 1'b1; reqKind = k; reqOffset = off; reqSize = sz;
    descBase = base; descLimit = lim; descPresent = p; descDpl = dpl;
    descExec = ex; descRw = rw; selRpl = rpl; curPl = cpl; protEn = pe;
    last = {1'b0, off} + {30'b0, sz} - 33'd1;
    isF  = (k == 2'b10);
    isW  = (k == 2'b01);
    tBad = isF ? !ex : (isW ? (ex || !rw) : (ex && !rw));
    it.g = 1'b0; it.vec = 8'd13;
    if (last > {1'b0, lim})                          it.vec = 8'd13;
    else if (pe && !p)                               it.vec = 8'd11;
    else if (pe && (cpl > dpl || (!isF && rpl > dpl))) it.vec = 8'd13;
    else if (pe && tBad)                             it.vec = 8'd13;
    else begin it.g = 1'b1; it.vec = 8'd0; expAddr = base + off; end
    it.addr = expAddr;
    it.due  = cyc + 1;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #2;
    reqValid = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (live) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        chk(grant == it.g && fault == !it.g, it.tag,
            $sformatf("grant=%0b fault=%0b", grant, fault),
            $sformatf("grant=%0b fault=%0b", it.g, !it.g));
        chk(faultVec == it.vec, it.tag, $sformatf("vec=%0d", faultVec),
            $sformatf("vec=%0d", it.vec));
        chk(linAddr == it.addr, it.tag, $sformatf("addr=%h", linAddr),
            $sformatf("addr=%h", it.addr));
      end else begin
        chk(!grant && !fault && faultVec == 8'd0, "R2 idle",
            $sformatf("grant=%0b fault=%0b vec=%0d", grant, fault, faultVec),
            "grant=0 fault=0 vec=0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!grant && !fault && faultVec == 0 && linAddr == 0, "R1 reset",
        $sformatf("g=%0b f=%0b v=%0d a=%h", grant, fault, faultVec, linAddr), "all zero");
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    chk(!grant && !fault && faultVec == 0 && linAddr == 0, "R1 after reset",
        $sformatf("g=%0b f=%0b v=%0d a=%h", grant, fault, faultVec, linAddr), "all zero");
    live = 1'b1;
    // kind off sz base lim p dpl ex rw rpl cpl pe
    req("R12 real read",      2'b00, 32'h20, 3'd4, 32'h1000, 32'hFF, 1, 0, 0, 1, 0, 0, 0);
    idle(2);
    req("R3 real over",       2'b00, 32'hFE, 3'd2, 32'h1000, 32'hFF, 1, 0, 0, 1, 0, 0, 0);
    req("R3 exact end",       2'b01, 32'hFC, 3'd4, 32'h2000, 32'hFF, 1, 3, 0, 1, 3, 3, 1);
    req("R3 wrap",            2'b00, 32'hFFFFFFFE, 3'd4, 32'h0, 32'hFFFFFFFF, 1, 0, 0, 1, 0, 0, 0);
    req("R4 real ignores",    2'b01, 32'h10, 3'd1, 32'h3000, 32'hFF, 0, 0, 1, 0, 3, 3, 0);
    req("R5 not present",     2'b00, 32'h10, 3'd1, 32'h4000, 32'hFF, 0, 3, 0, 1, 0, 0, 1);
    req("R6 rpl over",        2'b00, 32'h10, 3'd1, 32'h4000, 32'hFF, 1, 1, 0, 1, 2, 0, 1);
    req("R6 cpl over",        2'b01, 32'h10, 3'd1, 32'h4000, 32'hFF, 1, 1, 0, 1, 0, 2, 1);
    req("R7 fetch rpl ign",   2'b10, 32'h40, 3'd2, 32'h5000, 32'hFF, 1, 1, 1, 0, 3, 1, 1);
    req("R7 fetch cpl over",  2'b10, 32'h40, 3'd2, 32'h5000, 32'hFF, 1, 1, 1, 0, 0, 2, 1);
    req("R8 fetch data seg",  2'b10, 32'h40, 3'd2, 32'h5000, 32'hFF, 1, 3, 0, 1, 0, 0, 1);
    req("R9 read code noread",2'b00, 32'h8, 3'd4, 32'h6000, 32'hFF, 1, 3, 1, 0, 0, 0, 1);
    req("R9 read code ok",    2'b11, 32'h8, 3'd4, 32'h6000, 32'hFF, 1, 3, 1, 1, 0, 0, 1);
    req("R9 read data ro",    2'b00, 32'hC, 3'd1, 32'h7000, 32'hFF, 1, 3, 0, 0, 0, 0, 1);
    req("R10 write code",     2'b01, 32'h8, 3'd1, 32'h6000, 32'hFF, 1, 3, 1, 1, 0, 0, 1);
    req("R10 write ro data",  2'b01, 32'h8, 3'd1, 32'h7000, 32'hFF, 1, 3, 0, 0, 0, 0, 1);
    req("R11 limit over np",  2'b00, 32'h100, 3'd1, 32'h0, 32'hFF, 0, 0, 1, 0, 3, 3, 1);
    req("R11 np over priv",   2'b01, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 0, 1, 0, 3, 3, 1);
    req("R11 priv over type", 2'b01, 32'h0, 3'd1, 32'h0, 32'hFF, 1, 0, 1, 0, 3, 3, 1);
    req("R12 base wrap",      2'b01, 32'h20, 3'd2, 32'hFFFFFFF0, 32'hFF, 1, 2, 0, 1, 2, 2, 1);
    idle(3);
    done = 1'b1;
    live = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule